// File: doc/BRIEF.md
# Burst Mode Resolution Sequencer

This block takes the half-rate sample stream of one converter channel pair and turns it into bursts. Each burst holds a programmed number of full-precision 14-bit samples and then a programmed number of reduced-precision 9-bit samples. Every output beat carries a flag that says which precision it has. A burst starts in one of two ways. In automatic mode the sequencer starts the next burst as soon as the previous one ends. In manual mode it waits in an idle state and shows a trigger-ready level until the host drives the trigger input.

Both streams use valid/ready handshakes. A sample moves when valid and ready are high on the same rising clock edge. The output stage is one register per lane. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged. During a burst, `in_ready` is low only while that register is full and not being drained in the same cycle. In the idle state `in_ready` stays high and incoming samples are consumed and thrown away, so the stream from the decimator never stalls between bursts.

Top module: `bsq_burst_seq`

## Requirements
- R1: After reset the sequencer is idle, `trig_ready` is 1 and `out_valid` is 0.
- R2: In manual mode (`cfg_auto`=0), `trig_in` high at a clock edge while idle starts a burst, and `trig_ready` is 0 from that edge on. The sequencer leaves idle only through such a trigger or through automatic mode.
- R3: A burst emits `cfg_hi_count` beats with `out_hi_res`=1, followed by `cfg_lo_count` beats with `out_hi_res`=0. A count register value of 0 behaves as 1.
- R4: In a high-resolution beat, each 14-bit lane field of `out_data` equals the corresponding lane of the accepted input sample, unchanged.
- R5: In a low-resolution beat, each lane holds floor((x+16)/32) of its input x, a two's-complement 14-bit sample, limited to +255. The result is a 9-bit signed value in lane bits [8:0], and lane bits [13:9] are copies of bit 8.
- R6: `trig_in` has no effect while a burst is running. In manual mode the sequencer returns to idle after the last low-resolution beat is accepted.
- R7: While idle, `in_ready` is 1 and accepted samples produce no output beat.
- R8: In automatic mode (`cfg_auto`=1), the next burst begins with the sample accepted right after the last low-resolution sample, with no idle gap. `trig_ready` stays 0 throughout.
- R9: `cfg_hi_count` and `cfg_lo_count` are sampled when a burst starts. A change during a burst applies from the next burst on.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_hi_res` hold their values. During a burst `in_ready` is 0 exactly when the output register is full and `out_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_auto | input | 1 | 1: automatic re-triggering, 0: manual trigger |
| cfg_hi_count | input | CNT_W (8) | High-resolution beats per burst (0 acts as 1) |
| cfg_lo_count | input | CNT_W (8) | Low-resolution beats per burst (0 acts as 1) |
| trig_in | input | 1 | Manual burst trigger, sampled while idle |
| trig_ready | output | 1 | High while idle and able to take a trigger |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | LANES*SAMPLE_W (28) | Input lanes, lane i at bits [i*14 +: 14] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the beat when high |
| out_data | output | LANES*SAMPLE_W (28) | Output lanes, same layout as in_data |
| out_hi_res | output | 1 | 1: full-precision beat, 0: reduced-precision beat |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that `trig_in`, `cfg_auto` and the count registers are plain synchronous levels that settle before each edge. The bench changes every input one time unit after a rising edge. It raises the trigger only as a one-cycle pulse and moves the count registers only between sample transfers.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } bsq_state_e;
endpackage

// File: rtl/bsq_lane_fmt.sv
module bsq_lane_fmt #(
  parameter int SAMPLE_W = 14,
  parameter int LOW_W    = 9
) (
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic                hi_res_i,
  output logic [SAMPLE_W-1:0] smp_o
);
  localparam int SHIFT = SAMPLE_W - LOW_W;
  localparam logic signed [SAMPLE_W:0] HALF  = (SAMPLE_W+1)'(1 << (SHIFT-1));
  localparam logic signed [SAMPLE_W:0] LIMIT = (SAMPLE_W+1)'((1 << (LOW_W-1)) - 1);

  logic signed [SAMPLE_W:0] widened;
  logic signed [SAMPLE_W:0] biased;
  logic signed [SAMPLE_W:0] scaled;
  logic        [LOW_W-1:0]  coarse;

  always_comb begin
    widened = {smp_i[SAMPLE_W-1], smp_i};
    biased  = widened + HALF;
    scaled  = biased >>> SHIFT;
    coarse  = (scaled > LIMIT) ? LIMIT[LOW_W-1:0] : scaled[LOW_W-1:0];
    smp_o   = hi_res_i ? smp_i : {{SHIFT{coarse[LOW_W-1]}}, coarse};
  end
endmodule

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
  import bsq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_auto,
  input  logic [CNT_W-1:0] cfg_hi_count,
  input  logic [CNT_W-1:0] cfg_lo_count,
  input  logic             trig_in,
  input  logic             take_i,
  output logic             in_burst_o,
  output logic             hi_phase_o,
  output logic             idle_o
);
  bsq_state_e       state;
  logic [CNT_W-1:0] beat_cnt;
  logic [CNT_W-1:0] hi_last;
  logic [CNT_W-1:0] lo_last;

  function automatic logic [CNT_W-1:0] last_index(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      beat_cnt <= '0;
      hi_last  <= '0;
      lo_last  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cfg_auto || trig_in) begin
            hi_last  <= last_index(cfg_hi_count);
            lo_last  <= last_index(cfg_lo_count);
            beat_cnt <= '0;
            state    <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (take_i) begin
            if (beat_cnt == hi_last) begin
              beat_cnt <= '0;
              state    <= ST_LOW;
            end else begin
              beat_cnt <= beat_cnt + 1'b1;
            end
          end
        end
        ST_LOW: begin
          if (take_i) begin
            if (beat_cnt == lo_last) begin
              beat_cnt <= '0;
              if (cfg_auto) begin
                hi_last <= last_index(cfg_hi_count);
                lo_last <= last_index(cfg_lo_count);
                state   <= ST_HIGH;
              end else begin
                state   <= ST_IDLE;
              end
            end else begin
              beat_cnt <= beat_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle_o     = (state == ST_IDLE);
  assign in_burst_o = (state == ST_HIGH) || (state == ST_LOW);
  assign hi_phase_o = (state == ST_HIGH);
endmodule

// File: rtl/bsq_out_reg.sv
module bsq_out_reg #(
  parameter int DATA_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              hi_res_i,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_hi_res
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_hi_res <= 1'b0;
    end else if (load_i) begin
      out_valid  <= 1'b1;
      out_data   <= data_i;
      out_hi_res <= hi_res_i;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/bsq_burst_seq.sv
module bsq_burst_seq #(
  parameter int LANES    = 2,
  parameter int SAMPLE_W = 14,
  parameter int LOW_W    = 9,
  parameter int CNT_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_auto,
  input  logic [CNT_W-1:0]          cfg_hi_count,
  input  logic [CNT_W-1:0]          cfg_lo_count,
  input  logic                      trig_in,
  output logic                      trig_ready,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES*SAMPLE_W-1:0] in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES*SAMPLE_W-1:0] out_data,
  output logic                      out_hi_res
);
  localparam int DATA_W = LANES * SAMPLE_W;

  logic              in_burst;
  logic              hi_phase;
  logic              idle;
  logic              take;
  logic [DATA_W-1:0] fmt_data;

  assign in_ready   = idle || !out_valid || out_ready;
  assign take       = in_valid && in_ready && in_burst;
  assign trig_ready = idle;

  bsq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_auto     (cfg_auto),
    .cfg_hi_count (cfg_hi_count),
    .cfg_lo_count (cfg_lo_count),
    .trig_in      (trig_in),
    .take_i       (take),
    .in_burst_o   (in_burst),
    .hi_phase_o   (hi_phase),
    .idle_o       (idle)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bsq_lane_fmt #(.SAMPLE_W(SAMPLE_W), .LOW_W(LOW_W)) u_fmt (
      .smp_i    (in_data[g*SAMPLE_W +: SAMPLE_W]),
      .hi_res_i (hi_phase),
      .smp_o    (fmt_data[g*SAMPLE_W +: SAMPLE_W])
    );
  end

  bsq_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (take),
    .data_i     (fmt_data),
    .hi_res_i   (hi_phase),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_hi_res (out_hi_res)
  );
endmodule

// File: rtl/bsq_burst_seq_chk.sv
module bsq_burst_seq_chk #(
  parameter int LANES    = 2,
  parameter int SAMPLE_W = 14,
  parameter int LOW_W    = 9,
  parameter int CNT_W    = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_auto,
  input logic [CNT_W-1:0]          cfg_hi_count,
  input logic [CNT_W-1:0]          cfg_lo_count,
  input logic                      trig_in,
  input logic                      trig_ready,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic [LANES*SAMPLE_W-1:0] in_data,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [LANES*SAMPLE_W-1:0] out_data,
  input logic                      out_hi_res
);
  // R10: a stalled beat stays put
  assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_hi_res));

  // R2: idle is left only through a trigger or automatic mode
  assert_exit_idle_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_ready) |-> $past(trig_in || cfg_auto));

  // R7: the stream is never stalled while idle
  assert_idle_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ready |-> in_ready);

  // R5: reduced-precision lanes are sign-extended 9-bit values
  for (genvar g = 0; g < LANES; g++) begin : g_sx
    assert_low_sign_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_hi_res |->
        out_data[g*SAMPLE_W + LOW_W - 1 +: SAMPLE_W - LOW_W + 1] == '0 ||
        out_data[g*SAMPLE_W + LOW_W - 1 +: SAMPLE_W - LOW_W + 1] == '1);
  end
endmodule

bind bsq_burst_seq bsq_burst_seq_chk #(
  .LANES(LANES), .SAMPLE_W(SAMPLE_W), .LOW_W(LOW_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/bsq_burst_seq_test.sv
module bsq_burst_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 14;
  localparam int NTV = 6;
  // {lane0 input, lane0 expected low-res, lane1 input, lane1 expected low-res}
  localparam int TV [NTV][4] = '{
    '{0, 0, 8191, 255},
    '{15, 0, 16, 1},
    '{-8192, -256, -17, -1},
    '{-16, 0, 1000, 31},
    '{-1000, -31, 8160, 255},
    '{8175, 255, -9, 0}
  };

  logic         clk = 0;
  logic         rst_n = 0;
  logic         cfg_auto = 0;
  logic [7:0]   cfg_hi_count = 8'd1;
  logic [7:0]   cfg_lo_count = 8'd1;
  logic         trig_in = 0;
  logic         trig_ready;
  logic         in_valid = 0;
  logic         in_ready;
  logic [27:0]  in_data = '0;
  logic         out_valid;
  logic         out_ready = 1;
  logic [27:0]  out_data;
  logic         out_hi_res;

  int checks = 0;
  int fails = 0;
  int ncap = 0;
  logic [27:0] cap_data [512];
  logic        cap_hi   [512];
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsq_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_auto(cfg_auto), .cfg_hi_count(cfg_hi_count),
    .cfg_lo_count(cfg_lo_count), .trig_in(trig_in), .trig_ready(trig_ready),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_hi_res(out_hi_res)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && ncap < 512) begin
      cap_data[ncap] = out_data;
      cap_hi[ncap]   = out_hi_res;
      ncap++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  function automatic logic [27:0] pack(input int a, input int b);
    return {14'(b), 14'(a)};
  endfunction

  // called 1 time unit after a rising edge; returns 1 time unit after the transfer edge
  task automatic push(input logic [27:0] d);
    in_valid = 1;
    in_data  = d;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 0;
  endtask

  task automatic pulse_trig();
    trig_in = 1;
    @(posedge clk);
    #1;
    trig_in = 0;
  endtask

  task automatic chk_flags(input string req, input int base, input int n, input logic [15:0] pat);
    for (int i = 0; i < n; i++)
      chk(cap_hi[base+i] == pat[i], req, int'(cap_hi[base+i]), int'(pat[i]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1;
    cycles(1);
    // R1 reset state
    chk(trig_ready == 1, "R1 trig_ready", int'(trig_ready), 1);
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);

    // R7: samples while idle are dropped
    push(pack(5, 6));
    push(pack(7, 8));
    cycles(2);
    chk(ncap == 0, "R7 idle drops samples", ncap, 0);
    chk(in_ready == 1, "R7 in_ready idle", int'(in_ready), 1);

    // Vector table: rounding in both lanes, pass-through of high-res beat (R4, R5)
    for (int v = 0; v < NTV; v++) begin
      ncap = 0;
      pulse_trig();
      chk(trig_ready == 0, "R2 ready falls", int'(trig_ready), 0);
      push(pack(1234, -4321));
      push(pack(TV[v][0], TV[v][2]));
      cycles(2);
      chk(ncap == 2, "R3 beats per burst", ncap, 2);
      chk(cap_hi[0] == 1 && cap_hi[1] == 0, "R3 flag order", int'({cap_hi[0], cap_hi[1]}), 2);
      chk(cap_data[0] == pack(1234, -4321), "R4 hi pass-through", int'(cap_data[0]), int'(pack(1234, -4321)));
      chk(cap_data[1][13:0] == 14'(TV[v][1]), "R5 lane0 rounding", int'(cap_data[1][13:0]), int'(14'(TV[v][1])));
      chk(cap_data[1][27:14] == 14'(TV[v][3]), "R5 lane1 rounding", int'(cap_data[1][27:14]), int'(14'(TV[v][3])));
      chk(trig_ready == 1, "R6 back to idle", int'(trig_ready), 1);
    end

    // R3 counts 3/2; R6 trigger during burst ignored
    ncap = 0;
    cfg_hi_count = 8'd3;
    cfg_lo_count = 8'd2;
    pulse_trig();
    push(pack(100, -100));
    pulse_trig();
    push(pack(200, -200));
    push(pack(300, -300));
    pulse_trig();
    push(pack(64, -64));
    push(pack(64, -64));
    cycles(2);
    chk(ncap == 5, "R3 count 3+2", ncap, 5);
    chk_flags("R3 flags 3+2", 0, 5, 16'b00111);
    chk(cap_data[3][13:0] == 14'd2, "R5 round 64", int'(cap_data[3][13:0]), 2);
    chk(cap_data[4][27:14] == 14'(-2), "R5 round -64", int'(cap_data[4][27:14]), int'(14'(-2)));
    chk(trig_ready == 1, "R6 idle after manual burst", int'(trig_ready), 1);
    push(pack(9, 9));
    cycles(2);
    chk(ncap == 5, "R6 stray trigger ignored", ncap, 5);

    // R10 back-pressure
    ncap = 0;
    cfg_hi_count = 8'd2;
    cfg_lo_count = 8'd1;
    out_ready = 0;
    pulse_trig();
    push(pack(11, 12));
    cycles(3);
    chk(out_valid == 1, "R10 held valid", int'(out_valid), 1);
    chk(out_data == pack(11, 12), "R10 held data", int'(out_data), int'(pack(11, 12)));
    chk(in_ready == 0, "R10 in_ready low", int'(in_ready), 0);
    out_ready = 1;
    push(pack(21, 22));
    push(pack(320, 0));
    cycles(2);
    chk(ncap == 3, "R10 no loss", ncap, 3);
    chk(cap_data[0] == pack(11, 12) && cap_data[1] == pack(21, 22), "R10 order",
        int'(cap_data[1]), int'(pack(21, 22)));
    chk(cap_data[2][13:0] == 14'd10, "R5 round 320", int'(cap_data[2][13:0]), 10);

    // R8 automatic mode, R9 count latched at burst start
    ncap = 0;
    cfg_auto = 1;
    cycles(3);
    chk(trig_ready == 0, "R8 auto leaves idle", int'(trig_ready), 0);
    chk(ncap == 0, "R8 no beats before samples", ncap, 0);
    for (int k = 0; k < 7; k++) push(pack(k, k));
    cfg_hi_count = 8'd1;
    for (int k = 7; k < 11; k++) push(pack(k, k));
    cycles(2);
    chk(ncap == 11, "R8 beat count", ncap, 11);
    chk_flags("R8 R9 flags", 0, 11, 16'b01_011_011_011);
    chk(trig_ready == 0, "R8 ready stays low", int'(trig_ready), 0);
    cfg_auto = 0;
    push(pack(40, 40));
    push(pack(41, 41));
    cycles(2);
    chk(ncap == 13, "R9 new count used", ncap, 13);
    chk_flags("R9 flags next burst", 11, 2, 16'b01);
    chk(trig_ready == 1, "R8 manual after auto", int'(trig_ready), 1);

    // R3 zero counts act as one
    ncap = 0;
    cfg_hi_count = 8'd0;
    cfg_lo_count = 8'd0;
    pulse_trig();
    push(pack(1, 1));
    push(pack(2, 2));
    cycles(2);
    chk(ncap == 2, "R3 zero count", ncap, 2);
    chk_flags("R3 zero flags", 0, 2, 16'b01);
    chk(trig_ready == 1, "R3 zero back idle", int'(trig_ready), 1);

    // R1 reset mid-burst
    cfg_hi_count = 8'd4;
    pulse_trig();
    push(pack(3, 3));
    rst_n = 0;
    cycles(2);
    rst_n = 1;
    cycles(1);
    chk(trig_ready == 1, "R1 reset ready", int'(trig_ready), 1);
    chk(out_valid == 0, "R1 reset valid", int'(out_valid), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule